// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel that copies blocks of 32-bit words from one memory location to another. A small descriptor store holds the work. The active slot (slot 0) drives the copy that is running. The other slots are link slots that software fills ahead of time. Each descriptor names a source word address, a destination word address, a word count, a link index and an interrupt enable. Source and destination are full 32-bit pointers, so the elements of a chain need not be contiguous in memory.

A sync event from a peripheral starts the copy described by the active slot. When the last word of that element has been written, the hardware replaces the active slot with the descriptor that its link field names. The next element can then start without software taking part. Software keeps the chain going by rewriting link slots that are not in use while a copy runs.

A null link ends the chain. Events that arrive once the null descriptor is loaded are not lost silently: they raise a sticky missed-event flag. Software can replay them through a manual-trigger command.

Top module: `ldma_chan`

## Requirements
- R1: After a synchronous active-high reset, the channel is idle and has no memory request outstanding. The `irq`, `missed_flag` and `wr_err` outputs are all low, and the active slot holds the null descriptor (count 0, link 4'hF).
- R2: An element copies `count` words, one at a time. For each word, the engine issues one read at the current source address, then writes the returned data to the current destination address. Both addresses advance by one word address after each write. Each request holds its valid, address and data stable until ready is high. A read and a write are never requested in the same cycle.
- R3: An event on an idle channel starts the active descriptor when its count is non-zero. With a zero count, no access is made and the missed-event flag is set.
- R4: The write handshake that carries the last word of an element also loads the active slot from the link slot named by its link field, so the following cycle already sees the new descriptor. Link values 1 to NSLOT-1 select a link slot.
- R5: When the finishing descriptor has its interrupt enable set, `irq` is high for exactly one cycle, the cycle after that last write handshake. When the enable is clear, `irq` stays low.
- R6: A link value of 0, a value of NSLOT or above, or 4'hF (the null link) loads the null descriptor. Each later event sets the missed-event flag and makes no memory access.
- R7: An event that arrives during a copy is held in a single pending bit. If the reloaded descriptor has a non-zero count, that descriptor starts on the same edge as the reload. Otherwise the held event is reported as missed.
- R8: An event that arrives during a copy while the pending bit is already set raises the missed-event flag.
- R9: The missed-event flag is sticky and is cleared by writing 1 to bit 1 of a command word. A new miss in the same cycle takes precedence over the clear.
- R10: A write to the active slot while a copy runs has no effect on the copy. It sets the sticky `wr_err` flag, which is cleared by writing 1 to bit 2 of a command word. Writes to the active slot while idle are accepted and do not set `wr_err`.
- R11: Link slots can be written at any time, including during a copy, and the next reload uses the new contents. Register address `cfg_addr[3:2]` selects the slot and `cfg_addr[1:0]` selects the field: 0 is source, 1 is destination, 2 is control and 3 is command. The control field holds the count in bits 15:0, the link in bits 19:16 and the interrupt enable in bit 24.
- R12: Writing 1 to bit 0 of a command word issues one event, the same as `evt_in`. A command trigger and `evt_in` in the same cycle count as a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | SLOT_W+2 (4) | Slot index in the upper bits, field select in the low two bits |
| cfg_wdata | input | 32 | Register write data |
| evt_in | input | 1 | Sync event from the peripheral; one event per high cycle |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | 32 | Read word address |
| rd_rsp_valid | input | 1 | Read data is present |
| rd_rsp_data | input | DATA_W (32) | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Write word address |
| wr_data | output | DATA_W (32) | Write data |
| irq | output | 1 | One-cycle completion interrupt |
| missed_flag | output | 1 | Sticky missed-event flag |
| wr_err | output | 1 | Sticky flag for a write to the active slot while busy |

## Verification
The bench builds the channel with NSLOT = 4, which gives three link slots. With that value, a chain that runs through every link slot is within reach, and so is a link value of 0 that points back at the active slot. It compares the interrupt and both sticky flags every cycle against a behavioural model, and checks every write's address and data against the model's chain walk. Memory ready patterns alternate between always ready and irregular stalls, so the reload and the pending event are exercised both with back-to-back handshakes and with wait cycles.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  localparam int AW       = 32;
  localparam int CW       = 16;
  localparam int LW       = 4;
  localparam int LINK_LSB = 16;
  localparam int IE_BIT   = 24;
  localparam logic [LW-1:0] NULL_LINK = 4'hF;

  localparam int CMD_TRIG     = 0;
  localparam int CMD_CLR_MISS = 1;
  localparam int CMD_CLR_WERR = 2;

  typedef enum logic [1:0] {
    FLD_SRC  = 2'd0,
    FLD_DST  = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_CMD  = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RDREQ  = 2'd1,
    ST_RDWAIT = 2'd2,
    ST_WR     = 2'd3
  } xst_e;

  typedef struct packed {
    logic          ie;
    logic [LW-1:0] link;
    logic [CW-1:0] cnt;
    logic [AW-1:0] dst;
    logic [AW-1:0] src;
  } desc_t;

  localparam desc_t NULL_DESC = '{ie: 1'b0, link: NULL_LINK, cnt: '0, dst: '0, src: '0};
endpackage

// File: rtl/ldma_linkram.sv
module ldma_linkram
  import ldma_pkg::*;
#(
  parameter int NSLOT  = 4,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] widx,
  input  fld_e              wfld,
  input  logic [31:0]       wdata,
  input  logic [LW-1:0]     ridx,
  output desc_t             rdesc
);
  // Link descriptor store; entry 0 is never written (the active slot lives in the engine).
  logic [AW-1:0] src_m [NSLOT];
  logic [AW-1:0] dst_m [NSLOT];
  logic [CW-1:0] cnt_m [NSLOT];
  logic [LW-1:0] lnk_m [NSLOT];
  logic          ie_m  [NSLOT];

  always_ff @(posedge clk) begin
    if (we) begin
      case (wfld)
        FLD_SRC:  src_m[widx] <= wdata[AW-1:0];
        FLD_DST:  dst_m[widx] <= wdata[AW-1:0];
        FLD_CTRL: begin
          cnt_m[widx] <= wdata[CW-1:0];
          lnk_m[widx] <= wdata[LINK_LSB +: LW];
          ie_m[widx]  <= wdata[IE_BIT];
        end
        default: ;
      endcase
    end
  end

  // Only indices 1..NSLOT-1 name a link slot; everything else reads as the null descriptor.
  logic sel_ok;
  assign sel_ok = (ridx != '0) && (32'(ridx) < NSLOT);

  generate
    if (SLOT_W < LW) begin : g_narrow
      logic [SLOT_W-1:0] ri;
      assign ri = ridx[SLOT_W-1:0];
      always_comb begin
        rdesc = NULL_DESC;
        if (sel_ok) rdesc = '{ie: ie_m[ri], link: lnk_m[ri], cnt: cnt_m[ri], dst: dst_m[ri], src: src_m[ri]};
      end
    end else begin : g_wide
      logic [SLOT_W-1:0] ri;
      assign ri = SLOT_W'(ridx);
      always_comb begin
        rdesc = NULL_DESC;
        if (sel_ok) rdesc = '{ie: ie_m[ri], link: lnk_m[ri], cnt: cnt_m[ri], dst: dst_m[ri], src: src_m[ri]};
      end
    end
  endgenerate
endmodule

// File: rtl/ldma_evt.sv
module ldma_evt (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic busy,
  input  logic act_valid,
  input  logic done,
  input  logic next_valid,
  input  logic clr_miss,
  output logic start,
  output logic missed_flag
);
  logic pend_q, pend_d, miss;

  always_comb begin
    start  = 1'b0;
    miss   = 1'b0;
    pend_d = pend_q;
    if (done) begin
      if (next_valid) begin
        start  = pend_q | evt;
        pend_d = pend_q & evt;
      end else begin
        miss   = pend_q | evt;
        pend_d = 1'b0;
      end
    end else if (busy) begin
      if (evt) begin
        if (pend_q) miss = 1'b1;
        else        pend_d = 1'b1;
      end
    end else if (evt) begin
      if (act_valid) start = 1'b1;
      else           miss  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      missed_flag <= 1'b0;
    end else begin
      pend_q      <= pend_d;
      missed_flag <= miss | (missed_flag & ~clr_miss);
    end
  end
endmodule

// File: rtl/ldma_xfer.sv
module ldma_xfer
  import ldma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_we,
  input  fld_e              act_fld,
  input  logic [31:0]       act_wdata,
  input  logic              start,
  input  desc_t             nxt,
  output logic              busy,
  output logic              act_valid,
  output logic              done,
  output logic [LW-1:0]     act_link,
  output logic              irq,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  xst_e              st;
  logic [AW-1:0]     a_src, a_dst;
  logic [CW-1:0]     a_cnt;
  logic [LW-1:0]     a_link;
  logic              a_ie;
  logic [DATA_W-1:0] buf_q;

  assign busy         = (st != ST_IDLE);
  assign act_valid    = (a_cnt != '0);
  assign act_link     = a_link;
  assign done         = (st == ST_WR) && wr_ready && (a_cnt == CW'(1));
  assign rd_req_valid = (st == ST_RDREQ);
  assign rd_req_addr  = a_src;
  assign wr_valid     = (st == ST_WR);
  assign wr_addr      = a_dst;
  assign wr_data      = buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      a_src  <= '0;
      a_dst  <= '0;
      a_cnt  <= '0;
      a_link <= NULL_LINK;
      a_ie   <= 1'b0;
      buf_q  <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= done & a_ie;
      case (st)
        ST_IDLE: begin
          if (act_we) begin
            case (act_fld)
              FLD_SRC:  a_src <= act_wdata[AW-1:0];
              FLD_DST:  a_dst <= act_wdata[AW-1:0];
              FLD_CTRL: begin
                a_cnt  <= act_wdata[CW-1:0];
                a_link <= act_wdata[LINK_LSB +: LW];
                a_ie   <= act_wdata[IE_BIT];
              end
              default: ;
            endcase
          end
          if (start) st <= ST_RDREQ;
        end
        ST_RDREQ: if (rd_req_ready) st <= ST_RDWAIT;
        ST_RDWAIT: begin
          if (rd_rsp_valid) begin
            buf_q <= rd_rsp_data;
            st    <= ST_WR;
          end
        end
        ST_WR: begin
          if (wr_ready) begin
            if (a_cnt == CW'(1)) begin
              // element finished: reload the active slot from the linked descriptor
              a_src  <= nxt.src;
              a_dst  <= nxt.dst;
              a_cnt  <= nxt.cnt;
              a_link <= nxt.link;
              a_ie   <= nxt.ie;
              st     <= start ? ST_RDREQ : ST_IDLE;
            end else begin
              a_src <= a_src + AW'(1);
              a_dst <= a_dst + AW'(1);
              a_cnt <= a_cnt - CW'(1);
              st    <= ST_RDREQ;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldma_chan.sv
module ldma_chan
  import ldma_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int DATA_W = 32,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SLOT_W+1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              evt_in,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [31:0]       rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [31:0]       wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              irq,
  output logic              missed_flag,
  output logic              wr_err
);
  fld_e              fld;
  logic [SLOT_W-1:0] slot;
  logic              is_cmd, fld_we, act_hit;
  logic              act_we, link_we, werr_set;
  logic              evt, clr_miss, clr_werr;
  logic              busy, act_valid, done, start;
  logic [LW-1:0]     act_link;
  desc_t             nxt;

  assign fld      = fld_e'(cfg_addr[1:0]);
  assign slot     = cfg_addr[SLOT_W+1:2];
  assign is_cmd   = cfg_we && (fld == FLD_CMD);
  assign fld_we   = cfg_we && (fld != FLD_CMD);
  assign act_hit  = fld_we && (slot == '0);
  assign act_we   = act_hit && !busy;
  assign werr_set = act_hit && busy;
  assign link_we  = fld_we && (slot != '0);
  assign evt      = evt_in | (is_cmd & cfg_wdata[CMD_TRIG]);
  assign clr_miss = is_cmd & cfg_wdata[CMD_CLR_MISS];
  assign clr_werr = is_cmd & cfg_wdata[CMD_CLR_WERR];

  ldma_linkram #(.NSLOT(NSLOT)) u_ram (
    .clk  (clk),
    .we   (link_we),
    .widx (slot),
    .wfld (fld),
    .wdata(cfg_wdata),
    .ridx (act_link),
    .rdesc(nxt)
  );

  ldma_evt u_evt (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .busy       (busy),
    .act_valid  (act_valid),
    .done       (done),
    .next_valid (nxt.cnt != '0),
    .clr_miss   (clr_miss),
    .start      (start),
    .missed_flag(missed_flag)
  );

  ldma_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk         (clk),
    .rst         (rst),
    .act_we      (act_we),
    .act_fld     (fld),
    .act_wdata   (cfg_wdata),
    .start       (start),
    .nxt         (nxt),
    .busy        (busy),
    .act_valid   (act_valid),
    .done        (done),
    .act_link    (act_link),
    .irq         (irq),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_addr (rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data (rd_rsp_data),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= werr_set | (wr_err & ~clr_werr);
  end
endmodule

// File: rtl/ldma_chan_chk.sv
module ldma_chan_chk
  import ldma_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int DATA_W = 32,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [SLOT_W+1:0] cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [31:0]       rd_req_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [31:0]       wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq,
  input logic              missed_flag,
  input logic              wr_err
);
  logic cmd_w;
  assign cmd_w = cfg_we && (cfg_addr[1:0] == 2'd3);

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  p_wr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_one_access_r2: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_valid && wr_valid));

  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_after_wr_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(wr_valid && wr_ready));

  p_miss_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    missed_flag && !(cmd_w && cfg_wdata[CMD_CLR_MISS]) |=> missed_flag);

  p_werr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    wr_err && !(cmd_w && cfg_wdata[CMD_CLR_WERR]) |=> wr_err);

  p_werr_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_err) |-> $past(cfg_we && cfg_addr[SLOT_W+1:2] == '0));
endmodule

bind ldma_chan ldma_chan_chk #(.NSLOT(NSLOT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq(irq), .missed_flag(missed_flag), .wr_err(wr_err)
);

// File: tb/sim_ldma_chan.sv
`timescale 1ns/1ps
module sim_ldma_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        evt_in = 1'b0;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_addr, wr_data;
  logic        irq, missed_flag, wr_err;

  always #2 clk = ~clk;

  ldma_chan #(.NSLOT(4), .DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .evt_in(evt_in), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .missed_flag(missed_flag), .wr_err(wr_err)
  );

  int nchk = 0;
  int nerr = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [31:0] ctl(input int cnt, input int link, input bit ie);
    return (32'(ie) << 24) | (32'(link & 15) << 16) | 32'(cnt & 16'hFFFF);
  endfunction

  // memory responder
  logic [7:0] tick = '0;
  bit stall = 0;
  assign rd_req_ready = stall ? tick[0] : 1'b1;
  assign wr_ready     = stall ? (tick[1:0] != 2'b00) : 1'b1;
  always @(posedge clk) begin
    tick <= tick + 8'd1;
    if (rst) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end else begin
      rd_rsp_valid <= rd_req_valid && rd_req_ready;
      rd_rsp_data  <= memf(rd_req_addr);
    end
  end

  // behavioural reference model, advanced at each falling edge
  logic [31:0] ms [4];
  logic [31:0] md [4];
  int          mc [4];
  int          ml [4];
  bit          mi [4];
  bit          m_busy, m_pend, m_miss, m_werr, m_irq;
  int          w_left;
  logic [31:0] w_src, w_dst;
  int          wr_total = 0;
  int          irq_total = 0;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin ms[i] = '0; md[i] = '0; mc[i] = 0; ml[i] = 15; mi[i] = 0; end
      m_busy = 0; m_pend = 0; m_miss = 0; m_werr = 0; m_irq = 0; w_left = 0;
    end else begin
      bit cmd, evt, hs, done, busy_now, nvalid, start, miss, irq_n;
      int k, slot, fld;
      logic [31:0] ns, nd; int nc, nl; bit ni;
      chk(irq == m_irq, "R5 irq", 32'(irq), 32'(m_irq));
      chk(missed_flag == m_miss, "R9 missed_flag", 32'(missed_flag), 32'(m_miss));
      chk(wr_err == m_werr, "R10 wr_err", 32'(wr_err), 32'(m_werr));
      if (wr_valid) chk(m_busy, "R3 write only while copying", 32'(wr_valid), 32'(m_busy));
      if (irq) irq_total++;
      cmd = cfg_we && (cfg_addr[1:0] == 2'd3);
      evt = evt_in || (cmd && cfg_wdata[0]);
      hs = wr_valid && wr_ready;
      done = 0;
      busy_now = m_busy;
      if (hs) begin
        chk(wr_addr == w_dst, "R2/R4/R11 write address", wr_addr, w_dst);
        chk(wr_data == memf(w_src), "R2 write data", wr_data, memf(w_src));
        wr_total++;
        w_src++; w_dst++; w_left--;
        done = (w_left == 0);
      end
      k = ml[0];
      if (k >= 1 && k <= 3) begin ns = ms[k]; nd = md[k]; nc = mc[k]; nl = ml[k]; ni = mi[k]; end
      else begin ns = '0; nd = '0; nc = 0; nl = 15; ni = 0; end
      nvalid = (nc != 0);
      irq_n = done && mi[0];
      start = 0; miss = 0;
      if (done) begin
        if (nvalid) begin start = m_pend || evt; m_pend = m_pend && evt; end
        else begin miss = m_pend || evt; m_pend = 0; end
        ms[0] = ns; md[0] = nd; mc[0] = nc; ml[0] = nl; mi[0] = ni;
        m_busy = 0;
      end else if (m_busy) begin
        if (evt) begin if (m_pend) miss = 1; else m_pend = 1; end
      end else if (evt) begin
        if (mc[0] != 0) start = 1; else miss = 1;
      end
      if (cfg_we && !cmd) begin
        slot = int'(cfg_addr[3:2]);
        fld = int'(cfg_addr[1:0]);
        if (slot == 0 && busy_now) m_werr = 1;
        else begin
          if (fld == 0) ms[slot] = cfg_wdata;
          else if (fld == 1) md[slot] = cfg_wdata;
          else begin mc[slot] = int'(cfg_wdata[15:0]); ml[slot] = int'(cfg_wdata[19:16]); mi[slot] = cfg_wdata[24]; end
        end
      end else if (cmd && cfg_wdata[2] && !(cfg_addr[3:2] == 2'd0 && 1'b0)) begin
        m_werr = 0;
      end
      if (start) begin m_busy = 1; w_left = mc[0]; w_src = ms[0]; w_dst = md[0]; end
      m_miss = miss || (m_miss && !(cmd && cfg_wdata[1]));
      m_irq = irq_n;
    end
  end

  task automatic cfg(input int slot, input int fld, input logic [31:0] d);
    cfg_addr = 4'((slot << 2) | fld);
    cfg_wdata = d;
    cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic pulse();
    evt_in = 1'b1;
    @(posedge clk); #1;
    evt_in = 1'b0;
  endtask

  task automatic quiet();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!m_busy && !m_pend) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic program_desc(input int s, input logic [31:0] src, input logic [31:0] dst, input int cnt, input int link, input bit ie);
    cfg(s, 0, src);
    cfg(s, 1, dst);
    cfg(s, 2, ctl(cnt, link, ie));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!rd_req_valid && !wr_valid, "R1 no request after reset", {rd_req_valid, wr_valid}, 0);
    chk(!irq && !missed_flag && !wr_err, "R1 flags low after reset", {irq, missed_flag, wr_err}, 0);
    @(posedge clk); #1;

    // chain through slots 1 and 2, second event held pending (R4, R7)
    program_desc(1, 32'h2000, 32'h0900, 2, 2, 0);
    program_desc(2, 32'h3000, 32'h0A00, 1, 15, 1);
    program_desc(0, 32'h0100, 32'h0800, 3, 1, 1);
    pulse();
    @(posedge clk); #1;
    pulse();
    quiet();
    chk(wr_total == 5, "R4 words after reload chain", 32'(wr_total), 5);
    chk(irq_total == 1, "R5 interrupts after first chain", 32'(irq_total), 1);
    pulse();
    quiet();
    chk(wr_total == 6 && irq_total == 2, "R4 last element before null", 32'(wr_total), 6);
    pulse();
    @(negedge clk); @(posedge clk); #1;
    chk(missed_flag == 1'b1, "R6 event after null link", 32'(missed_flag), 1);
    cfg(0, 3, 32'h2);
    @(negedge clk);
    chk(missed_flag == 1'b0, "R9 write-one clear", 32'(missed_flag), 0);
    @(posedge clk); #1;

    // double event while busy, active write while busy, link slot rewrite while busy
    program_desc(1, 32'h6000, 32'h0F00, 2, 15, 0);
    program_desc(0, 32'h4000, 32'h0B00, 6, 1, 0);
    pulse();
    pulse();
    pulse();
    cfg(0, 0, 32'hDEAD);
    program_desc(1, 32'h5000, 32'h0C00, 2, 3, 1);
    program_desc(3, 32'h7000, 32'h0D00, 1, 0, 1);
    quiet();
    chk(missed_flag == 1'b1, "R8 second event while pending", 32'(missed_flag), 1);
    chk(wr_err == 1'b1, "R10 active write while busy", 32'(wr_err), 1);
    chk(wr_total == 14 && irq_total == 3, "R11 recycled link slot used", 32'(wr_total), 14);
    cfg(0, 3, 32'h1);
    quiet();
    chk(wr_total == 15 && irq_total == 4, "R12 manual trigger runs element", 32'(wr_total), 15);
    cfg(0, 3, 32'h6);
    @(negedge clk);
    chk(!missed_flag && !wr_err, "R9 R10 clear both flags", {missed_flag, wr_err}, 0);
    @(posedge clk); #1;
    pulse();
    @(negedge clk); @(posedge clk); #1;
    chk(missed_flag == 1'b1 && wr_total == 15, "R6 link value 0 is null", 32'(missed_flag), 1);
    cfg(0, 3, 32'h2);

    // pending event meets a null reload (R7)
    program_desc(0, 32'h8000, 32'h0E00, 2, 15, 0);
    pulse();
    pulse();
    quiet();
    @(negedge clk);
    chk(missed_flag == 1'b1 && wr_total == 17, "R7 pending event into null", 32'(missed_flag), 1);
    @(posedge clk); #1;
    cfg(0, 3, 32'h2);

    // stalled memory, ring through all link slots, coincident trigger and event (R12)
    stall = 1;
    program_desc(1, 32'h9000, 32'h0100, 3, 2, 1);
    program_desc(2, 32'hA000, 32'h0200, 2, 3, 0);
    program_desc(3, 32'hB000, 32'h0300, 2, 15, 1);
    program_desc(0, 32'hC000, 32'h0400, 1, 1, 0);
    pulse();
    pulse();
    quiet();
    pulse();
    quiet();
    cfg_addr = 4'h3; cfg_wdata = 32'h1; cfg_we = 1'b1; evt_in = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0; evt_in = 1'b0;
    quiet();
    @(negedge clk);
    chk(wr_total == 25 && irq_total == 6, "R2 R4 stalled ring of link slots", 32'(wr_total), 25);
    chk(missed_flag == 1'b0, "R12 coincident trigger counts once", 32'(missed_flag), 0);
    @(posedge clk); #1;
    stall = 0;

    // zero count on an idle channel (R3)
    cfg(0, 2, ctl(0, 1, 1));
    pulse();
    repeat (3) @(posedge clk); #1;
    chk(missed_flag == 1'b1 && wr_total == 25, "R3 zero count is missed", 32'(missed_flag), 1);
    chk(wr_err == 1'b0, "R10 idle active write accepted", 32'(wr_err), 0);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule